// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs the result of a plain binary addition of two packed-BCD bytes so that it again holds two valid decimal digits. The caller presents the byte that came out of the adder, the carry flag and the half-carry flag from that addition. The unit returns the corrected byte and an updated carry flag, which reads as the hundreds digit of the decimal sum. The half-carry is consumed only, and no overflow flag is involved.

The correction runs one digit at a time, lowest first. A digit that is above nine, or whose incoming flag is set, has six added to it. That addition spans the full word, so it can ripple into the digits above. For the lowest digit the incoming flag is the half-carry. For every digit above it, the incoming flag is the carry as it stands after the lower corrections. A carry out of the word can set the carry flag, but nothing clears it.

The whole adjust is combinational. The result is captured in output registers, so it appears one clock edge after the operands are presented. A new operand set can be accepted on every cycle. The number of digits is a parameter, with a default of two (one byte).

Top module: `dadj_unit`

## Requirements
- R1: Digit 0 (bits 3:0) is corrected, meaning 06h is added to the whole byte, exactly when that digit exceeds 9 or `ac_i` is 1. When it is not corrected and the carry stays clear, bits 3:0 of the result equal bits 3:0 of the input.
- R2: A carry out of bit 7 from the 06h addition sets the carry. For example, FAh with both flags clear gives 60h with carry 1, and 9Ah with both flags clear gives 00h with carry 1.
- R3: The carry is never cleared. When `cy_i` is 1, `cy_o` is 1 for that operand set.
- R4: After the first step, 60h is added when the carry is set or bits 7:4 exceed 9. A carry out of that addition sets the carry; otherwise the carry keeps its value. For example, A3h with both flags clear gives 03h with carry 1, and 12h with the carry set gives 72h with carry 1.
- R5: The result minus the input, taken modulo 256, is always one of 00h, 06h, 60h or 66h. For example, 00h with both flags set gives 66h with carry 1.
- R6: `acc_o` and `cy_o` are registered. They show the adjusted value for the inputs present at one rising edge from that edge onward. A synchronous active-high `rst` clears them to 00h and 0.
- R7: BEh with both flags clear gives 24h with carry 1. C9h with both flags clear gives 29h with carry 1.
- R8: Take any two valid packed-BCD bytes A and B and carry-in c. Add them in binary, with the half-carry taken from bit 3 and the carry from bit 7. Adjusting that sum yields (A+B+c) mod 100 in packed BCD, with carry 1 exactly when A+B+c is at least 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 4*NDIG | Byte from the binary adder |
| cy_i | input | 1 | Carry flag after the addition |
| ac_i | input | 1 | Half-carry flag after the addition |
| acc_o | output | 4*NDIG | Adjusted packed-BCD value, registered |
| cy_o | output | 1 | Updated carry flag, registered |

## Verification
Every result of this unit is due exactly one rising edge after its operands are presented. The bench drives each operand set just after a falling edge and compares `acc_o` and `cy_o` at the following falling edge, half a period after the capturing edge. A separate check samples the output just after new operands are driven, before any edge, to show the registers hold the previous result. Back-to-back streaming, a reset applied while operands are present, and every BCD operand pair with and without carry-in all use the same one-edge spacing.

// File: rtl/dadj_pkg.sv
`timescale 1ns/1ps
package dadj_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_MAX_DEC = 4'd9;
  localparam logic [NIB_W-1:0] NIB_FIX = 4'd6;

  function automatic logic digit_invalid(input logic [NIB_W-1:0] d);
    return d > NIB_MAX_DEC;
  endfunction
endpackage

// File: rtl/dadj_digit_fix.sv
`timescale 1ns/1ps
module dadj_digit_fix
  import dadj_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned IDX = 0
) (
  input  logic [W-1:0] val_i,
  input  logic         force_i,
  input  logic         cy_i,
  output logic [W-1:0] val_o,
  output logic         cy_o
);
  localparam int unsigned LSB = IDX * NIB_W;

  logic [NIB_W-1:0] digit;
  logic             fire;
  logic [W:0]       addend;
  logic [W:0]       sum;

  assign digit = val_i[LSB +: NIB_W];
  assign fire  = force_i | digit_invalid(digit);

  always_comb begin
    addend = '0;
    if (fire) addend[LSB +: NIB_W] = NIB_FIX;
  end

  // the addition spans the full word so a fix may ripple upward
  assign sum   = {1'b0, val_i} + addend;
  assign val_o = sum[W-1:0];
  // sticky: a carry out can only set the flag
  assign cy_o  = cy_i | sum[W];
endmodule

// File: rtl/dadj_unit.sv
`timescale 1ns/1ps
module dadj_unit
  import dadj_pkg::*;
#(
  parameter int unsigned NDIG = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NDIG*NIB_W-1:0] acc_i,
  input  logic                  cy_i,
  input  logic                  ac_i,
  output logic [NDIG*NIB_W-1:0] acc_o,
  output logic                  cy_o
);
  localparam int unsigned W = NDIG * NIB_W;

  logic [NDIG:0][W-1:0] val_chain;
  logic [NDIG:0]        cy_chain;

  assign val_chain[0] = acc_i;
  assign cy_chain[0]  = cy_i;

  for (genvar k = 0; k < NDIG; k++) begin : g_fix
    logic trig;
    if (k == 0) begin : g_low
      assign trig = ac_i;
    end else begin : g_up
      assign trig = cy_chain[k];
    end
    dadj_digit_fix #(.W(W), .IDX(k)) u_fix (
      .val_i   (val_chain[k]),
      .force_i (trig),
      .cy_i    (cy_chain[k]),
      .val_o   (val_chain[k+1]),
      .cy_o    (cy_chain[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      cy_o  <= 1'b0;
    end else begin
      acc_o <= val_chain[NDIG];
      cy_o  <= cy_chain[NDIG];
    end
  end

  // primed is high only when the previous edge was outside reset
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  function automatic logic net_fix_ok(input logic [W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NDIG; k++) begin
      if (d[k*NIB_W +: NIB_W] != '0 && d[k*NIB_W +: NIB_W] != NIB_FIX) ok = 1'b0;
    end
    return ok;
  endfunction

  // R1
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(ac_i) && !$past(cy_i) && ($past(acc_i[3:0]) <= NIB_MAX_DEC))
      |-> (acc_o[3:0] == $past(acc_i[3:0])));

  // R3
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(cy_i)) |-> cy_o);

  // R5
  net_fix_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> net_fix_ok(acc_o - $past(acc_i)));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && !cy_o));
endmodule

// File: tb/dadj_unit_test.sv
`timescale 1ns/1ps
module dadj_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_i = '0;
  logic       cy_i = 1'b0;
  logic       ac_i = 1'b0;
  logic [7:0] acc_o;
  logic       cy_o;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dadj_unit #(.NDIG(2)) uut (
    .clk(clk), .rst(rst), .acc_i(acc_i), .cy_i(cy_i), .ac_i(ac_i),
    .acc_o(acc_o), .cy_o(cy_o)
  );

  // model built from R1, R2, R4
  function automatic logic [8:0] ref_fix(input logic [7:0] a, input logic c, input logic h);
    logic [8:0] s;
    logic       cy;
    cy = c;
    s  = {1'b0, a};
    if (a[3:0] > 4'd9 || h) begin
      s  = {1'b0, s[7:0]} + 9'h006;
      cy = cy | s[8];
    end
    if (cy || s[7:4] > 4'd9) begin
      s  = {1'b0, s[7:0]} + 9'h060;
      cy = cy | s[8];
    end
    return {cy, s[7:0]};
  endfunction

  task automatic check(input logic [7:0] ea, input logic ec, input string req);
    total++;
    if (acc_o !== ea || cy_o !== ec) begin
      fails++;
      $display("FAIL %s: got acc=%02h cy=%0b, expected acc=%02h cy=%0b", req, acc_o, cy_o, ea, ec);
    end
  endtask

  // called right after a falling edge; result checked one edge later
  task automatic apply(input logic [7:0] a, input logic c, input logic h,
                       input logic [7:0] ea, input logic ec, input string req);
    acc_i = a; cy_i = c; ac_i = h;
    @(negedge clk);
    check(ea, ec, req);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20211));
    repeat (3) @(negedge clk);
    check(8'h00, 1'b0, "R6 reset state");
    rst = 1'b0;

    apply(8'h55, 1'b0, 1'b0, 8'h55, 1'b0, "R1 no fix");
    // R6: new operands do not reach the output before an edge
    acc_i = 8'h0A; cy_i = 1'b0; ac_i = 1'b0;
    #1;
    check(8'h55, 1'b0, "R6 hold before edge");
    @(negedge clk);
    check(8'h10, 1'b0, "R1 low digit over nine");
    apply(8'h23, 1'b0, 1'b1, 8'h29, 1'b0, "R1 half-carry forces fix");
    apply(8'hFA, 1'b0, 1'b0, 8'h60, 1'b1, "R2 carry from first step");
    apply(8'h9A, 1'b0, 1'b0, 8'h00, 1'b1, "R2 ripple into high digit");
    apply(8'hA3, 1'b0, 1'b0, 8'h03, 1'b1, "R4 high digit over nine");
    apply(8'h12, 1'b1, 1'b0, 8'h72, 1'b1, "R3 carry kept and R4 forced");
    apply(8'h99, 1'b1, 1'b1, 8'hFF, 1'b1, "R3 carry kept with no overflow");
    apply(8'h00, 1'b1, 1'b1, 8'h66, 1'b1, "R5 full 66h correction");
    apply(8'hBE, 1'b0, 1'b0, 8'h24, 1'b1, "R7 first example");
    apply(8'hC9, 1'b0, 1'b0, 8'h29, 1'b1, "R7 second example");

    rst = 1'b1;
    apply(8'h99, 1'b1, 1'b1, 8'h00, 1'b0, "R6 reset while operands present");
    rst = 1'b0;

    // R8: every BCD pair, with and without carry-in
    for (int a = 0; a < 100; a++) begin
      for (int b = 0; b < 100; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [7:0] ab, bb, ea;
          logic [8:0] s;
          logic       h;
          int         t;
          ab = 8'((a / 10) * 16 + (a % 10));
          bb = 8'((b / 10) * 16 + (b % 10));
          s  = {1'b0, ab} + {1'b0, bb} + 9'(c);
          h  = ({1'b0, ab[3:0]} + {1'b0, bb[3:0]} + 5'(c)) > 5'd15;
          t  = a + b + c;
          ea = 8'(((t % 100) / 10) * 16 + (t % 10));
          apply(s[7:0], s[8], h, ea, (t >= 100), "R8 decimal sum");
        end
      end
    end

    // R5 and model across arbitrary inputs
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic       c, h;
      logic [8:0] r;
      a = 8'($urandom);
      c = 1'($urandom);
      h = 1'($urandom);
      r = ref_fix(a, c, h);
      apply(a, c, h, r[7:0], r[8], "R5 random against model");
      total++;
      if (!((8'(acc_o - a)) inside {8'h00, 8'h06, 8'h60, 8'h66})) begin
        fails++;
        $display("FAIL R5: got delta=%02h, expected one of 00/06/60/66", 8'(acc_o - a));
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule